// File: doc/BRIEF.md
# Eight-bit Compare Timer with Output Drive

This block is an up-counting timer with a clock divider in front of it, a compare register and a separate period register. A one-cycle enable input (`tick_en`) paces the timer. A prescaler thins those ticks into counter steps. The counter then advances, and the block compares it against the two registers.

Two modes decide where the count wraps:
- **Clear-on-match mode:** the compare register sets the top value.
- **Pulse-width mode:** the period register sets the top, and the compare register sets the duty.

In both modes the wrap to zero happens on the step after the counter reaches the top value, so a top of N gives a period of N+1 steps.

A two-bit output mode selects what the compare event does to an output register:
- 00: the timer does not drive the output at all.
- 01: the output toggles.
- 10: the output is cleared.
- 11: the output is set.

That register reaches the pin only while the direction input allows it. A registered flag pulses each time the count arrives at the compare value.

Software-side configuration comes through a simple write port with three addresses. Writes to the compare and period registers act at once.

Top module: `tmr8_cmp_out`

## Requirements
- R1: A write with `wr_en`=1 stores `wr_data` at the next clock: address 0 is the control register, address 1 is compare A, and address 2 is period C. Control bits are: bit 7 clear-on-match, bit 6 pulse-width enable, bits 5:4 output mode, bits 3:0 clock select. After reset all three registers are 0, and `pin_oe`, `pin_out` and `match_a` are 0.
- R2: The counter steps only on a cycle with `tick_en`=1, as chosen by the clock select field:
  - 0 stops it.
  - 1 steps on every tick.
  - A code n of 2 or more steps on every 2^(n-1)-th tick. A free-running tick counter clears when that division is reached.
- R3: With clear-on-match=1 and pulse-width enable=0, the step after the count equals compare A loads 0.
- R4: With both mode bits 0, the count ignores compare A and runs 0..255, then wraps to 0.
- R5: With pulse-width enable=1, the step after the count equals period C loads 0, whatever compare A holds.
- R6: Outside pulse-width mode, a compare event (a step that brings the count to compare A) applies the output mode to the output register:
  - 01 inverts it.
  - 10 clears it.
  - 11 sets it.
  - 00 leaves it unchanged.
- R7: In pulse-width mode, the output register is updated on every step:
  - Mode 10: it is 1 while the new count is at most compare A, so compare A = 0 still gives a one-step pulse.
  - Mode 11: it is the inverse of mode 10.
  - Mode 01: it inverts on a compare event.
- R8: `pin_oe` is 1 only when `dir_en`=1 and the output mode is not 00. `pin_out` carries the output register while `pin_oe`=1 and is 0 otherwise.
- R9: `match_a` is 1 for exactly the clock cycle after each compare event.
- R10: A new compare A or period C value is used by the comparisons from the cycle after the write, without waiting for the counter to wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer clock enable, one pulse per timer input clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 compare A, 2 period C) |
| wr_data | input | CNT_W | Write data |
| dir_en | input | 1 | Direction gate for the output pin |
| pin_oe | output | 1 | Output pin driven by the timer |
| pin_out | output | 1 | Output pin level |
| match_a | output | 1 | One-cycle compare-A match flag |

## Verification
The bench builds the block with its default widths: an 8-bit counter and a 4-bit clock select. With these widths a full 256-step wrap with the mode bits clear takes only a few hundred cycles. They also make it practical to sweep every compare value 0..8 against every period 1..7 in all three pulse-width output modes. The clock select codes 0 to 6 are swept under an irregular tick pattern, which exposes the prescaler's division and its free-running clear. A cycle-by-cycle arithmetic model in the bench predicts the pin and flag on every cycle, including the cycles where compare or period is rewritten mid-count.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned CSW = 4;

  typedef enum logic [1:0] {
    OM_OFF = 2'b00,
    OM_TOG = 2'b01,
    OM_CLR = 2'b10,
    OM_SET = 2'b11
  } out_mode_e;

  typedef struct packed {
    logic           ctc;
    logic           pwm;
    out_mode_e      mode;
    logic [CSW-1:0] csel;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMPA = 2'd1;
  localparam logic [1:0] ADDR_PERC = 2'd2;
endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] cmpa_o,
  output logic [CNT_W-1:0] perc_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cmpa_q, cmpa_d, perc_q, perc_d;

  always_comb begin
    ctrl_d = ctrl_q;
    cmpa_d = cmpa_q;
    perc_d = perc_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: ctrl_d = ctrl_t'(wr_data[7:0]);
        ADDR_CMPA: cmpa_d = wr_data;
        ADDR_PERC: perc_d = wr_data;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmpa_q <= '0;
      perc_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmpa_q <= cmpa_d;
      perc_q <= perc_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign cmpa_o = cmpa_q;
  assign perc_o = perc_q;
endmodule

// File: rtl/tmr8_presc.sv
module tmr8_presc #(
  parameter int unsigned CSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic [CSW-1:0] csel,
  output logic           step_o
);
  localparam int unsigned PW = (1 << CSW) - 2;

  logic [PW-1:0] pre_q, pre_d, lim;
  logic [PW:0]   one_sh;

  always_comb begin
    one_sh = (PW+1)'(1) << (csel - CSW'(1));
    lim    = PW'(one_sh - (PW+1)'(1));
    step_o = tick_en && (csel != '0) && (pre_q >= lim);
    pre_d  = pre_q;
    if (csel == '0)   pre_d = '0;
    else if (step_o)  pre_d = '0;
    else if (tick_en) pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R2
  presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && csel > CSW'(1)) |=> (!$stable(csel) || !step_o));
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             ctc,
  input  logic             pwm,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] perc,
  output logic [CNT_W-1:0] nxt_o,
  output logic             hit_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, top;
  logic             match_q, wrap_en;

  always_comb begin
    top     = pwm ? perc : cmpa;
    wrap_en = pwm || ctc;
    cnt_d   = cnt_q;
    if (step) begin
      if (wrap_en && cnt_q == top) cnt_d = '0;
      else                         cnt_d = cnt_q + CNT_W'(1);
    end
    hit_o = step && (cnt_d == cmpa);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      match_q <= hit_o;
    end
  end

  assign nxt_o   = cnt_d;
  assign match_o = match_q;

  // R3
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ctc && !pwm && cnt_q == cmpa) |=> (cnt_q == '0));
  // R4
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ctc && !pwm) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));
  // R5
  pwm_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pwm && cnt_q == perc) |=> (cnt_q == '0));
  // R9
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> (cnt_q == $past(cmpa)));
endmodule

// File: rtl/tmr8_outgen.sv
module tmr8_outgen
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             hit,
  input  logic [CNT_W-1:0] nxt,
  input  logic [CNT_W-1:0] cmpa,
  input  logic             pwm,
  input  out_mode_e        mode,
  output logic             out_o
);
  logic out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (pwm) begin
      case (mode)
        OM_TOG:  if (hit)  out_d = ~out_q;
        OM_CLR:  if (step) out_d = (nxt <= cmpa);
        OM_SET:  if (step) out_d = (nxt > cmpa);
        default: ;
      endcase
    end else if (hit) begin
      case (mode)
        OM_TOG:  out_d = ~out_q;
        OM_CLR:  out_d = 1'b0;
        OM_SET:  out_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_o = out_q;

  // R6
  set_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !pwm && mode == OM_SET) |=> out_q);
  // R7
  pwm_zero_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pwm && mode == OM_CLR && nxt == '0) |=> out_q);
endmodule

// File: rtl/tmr8_cmp_out.sv
module tmr8_cmp_out
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             dir_en,
  output logic             pin_oe,
  output logic             pin_out,
  output logic             match_a
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmpa, perc, nxt;
  logic             step, hit, out_r;

  tmr8_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_o(ctrl), .cmpa_o(cmpa), .perc_o(perc)
  );

  tmr8_presc #(.CSW(CSW)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .csel(ctrl.csel),
    .step_o(step)
  );

  tmr8_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .ctc(ctrl.ctc), .pwm(ctrl.pwm),
    .cmpa(cmpa), .perc(perc), .nxt_o(nxt), .hit_o(hit), .match_o(match_a)
  );

  tmr8_outgen #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .step(step), .hit(hit), .nxt(nxt),
    .cmpa(cmpa), .pwm(ctrl.pwm), .mode(ctrl.mode), .out_o(out_r)
  );

  assign pin_oe  = dir_en && (ctrl.mode != OM_OFF);
  assign pin_out = pin_oe && out_r;
endmodule

// File: tb/sim_tmr8_cmp_out.sv
`timescale 1ns/1ps
module sim_tmr8_cmp_out;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, wr_en, dir_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       pin_oe, pin_out, match_a;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m_ctrl, m_a, m_c, m_cnt;
  int         m_pre;
  logic       m_match, m_out;

  always #2 clk = ~clk;

  tmr8_cmp_out u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .dir_en(dir_en),
    .pin_oe(pin_oe), .pin_out(pin_out), .match_a(match_a)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    logic eoe;
    eoe = dir_en && (m_ctrl[5:4] != 2'b00);
    chk("R8", "pin_oe", pin_oe, eoe);
    chk(tag, "pin_out", pin_out, eoe && m_out);
    chk("R9", "match_a", match_a, m_match);
  endtask

  // one clock: check outputs, drive inputs, advance the model
  task automatic cyc(input bit tk, input bit we, input logic [1:0] ad,
                     input logic [7:0] dt, input string tag);
    logic [3:0] cs;
    logic       step, hit, ctc, pwm;
    logic [1:0] md;
    logic [7:0] top, nc;
    int         div;
    @(negedge clk);
    compare(tag);
    tick_en = tk; wr_en = we; wr_addr = ad; wr_data = dt;
    cs = m_ctrl[3:0]; ctc = m_ctrl[7]; pwm = m_ctrl[6]; md = m_ctrl[5:4];
    step = 1'b0;
    if (cs == 4'd0) m_pre = 0;
    else begin
      div = 1 << (cs - 1);
      if (tk) begin
        if (m_pre >= div - 1) begin step = 1'b1; m_pre = 0; end
        else m_pre = m_pre + 1;
      end
    end
    top = pwm ? m_c : m_a;
    nc = m_cnt;
    if (step) nc = ((ctc || pwm) && m_cnt == top) ? 8'd0 : 8'(m_cnt + 8'd1);
    hit = step && (nc == m_a);
    if (pwm) begin
      case (md)
        2'b01: if (hit) m_out = ~m_out;
        2'b10: if (step) m_out = (nc <= m_a);
        2'b11: if (step) m_out = (nc > m_a);
        default: ;
      endcase
    end else if (hit) begin
      case (md)
        2'b01: m_out = ~m_out;
        2'b10: m_out = 1'b0;
        2'b11: m_out = 1'b1;
        default: ;
      endcase
    end
    m_match = hit;
    m_cnt = nc;
    if (we) begin
      case (ad)
        2'd0: m_ctrl = dt;
        2'd1: m_a = dt;
        2'd2: m_c = dt;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [1:0] ad, input logic [7:0] dt, input string tag);
    cyc(1'b0, 1'b1, ad, dt, tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 8'd0, tag);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_addr = 2'd0;
    wr_data = 8'd0; dir_en = 1'b1;
    m_ctrl = 0; m_a = 0; m_c = 0; m_cnt = 0; m_pre = 0; m_match = 0; m_out = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "reset pin_oe", pin_oe, 1'b0);
    chk("R1", "reset pin_out", pin_out, 1'b0);
    chk("R1", "reset match_a", match_a, 1'b0);
    rst_n = 1'b1;
    run(5, "R1");

    // R3: clear-on-match with toggle output, compare sweep
    wr(2'd0, 8'b1001_0001, "R1");
    for (int a = 0; a < 9; a++) begin
      wr(2'd1, 8'(a), "R3");
      run(40, "R3");
    end

    // R4 / R6: free-running counter in each non-PWM output mode
    wr(2'd1, 8'd100, "R4");
    for (int md = 1; md < 4; md++) begin
      wr(2'd0, {2'b00, 2'(md), 4'd1}, "R6");
      run(300, "R4");
    end
    // R6: clear-on-match with clear and set modes
    for (int md = 2; md < 4; md++) begin
      wr(2'd0, {2'b10, 2'(md), 4'd1}, "R6");
      for (int a = 0; a < 5; a++) begin
        wr(2'd1, 8'(a), "R6");
        run(15, "R6");
      end
    end

    // R5 / R7: pulse-width sweep of period, compare and output mode
    for (int md = 1; md < 4; md++) begin
      wr(2'd0, {2'b01, 2'(md), 4'd1}, "R7");
      for (int c = 1; c < 8; c++) begin
        wr(2'd2, 8'(c), "R5");
        for (int a = 0; a < 9; a++) begin
          wr(2'd1, 8'(a), "R7");
          run(20, "R7");
        end
      end
    end
    // R5: both mode bits set, the period register still sets the top
    wr(2'd0, 8'b1110_0001, "R5");
    wr(2'd2, 8'd6, "R5");
    wr(2'd1, 8'd2, "R5");
    run(40, "R5");

    // R2: clock select sweep with an irregular tick pattern
    for (int cs = 0; cs < 7; cs++) begin
      wr(2'd0, {4'b1001, 4'(cs)}, "R2");
      wr(2'd1, 8'd3, "R2");
      for (int i = 0; i < 260; i++)
        cyc((i % 3) != 0 || (i % 7) == 0, 1'b0, 2'd0, 8'd0, "R2");
    end
    // R2: shrink the division while the tick counter is large
    wr(2'd0, 8'b1001_0110, "R2");
    run(25, "R2");
    wr(2'd0, 8'b1001_0011, "R2");
    run(30, "R2");

    // R8: direction gate off, then mode 00 with the gate on
    wr(2'd0, 8'b1001_0001, "R8");
    dir_en = 1'b0;
    run(30, "R8");
    dir_en = 1'b1;
    wr(2'd0, 8'b1000_0001, "R8");
    run(30, "R8");

    // R10: rewrite compare and period mid-count
    wr(2'd0, 8'b0110_0001, "R10");
    wr(2'd2, 8'd7, "R10");
    wr(2'd1, 8'd3, "R10");
    for (int i = 0; i < 60; i++) begin
      if (i % 5 == 2) cyc(1'b1, 1'b1, 2'd1, 8'(i % 7), "R10");
      else if (i % 11 == 4) cyc(1'b1, 1'b1, 2'd2, 8'(3 + i % 5), "R10");
      else cyc(1'b1, 1'b0, 2'd0, 8'd0, "R10");
    end
    run(2, "R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #760000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule